// File: doc/BRIEF.md
# Tile-graphics bank address mapper

This block turns a 13-bit pattern-table fetch address from the picture processor into a physical address in a large graphics ROM. Eight 16-bit bank registers hold bank numbers. A granularity field picks the window size: one 8 KB window, two 4 KB halves, four 2 KB windows or eight 1 KB windows. An outer-block register can confine all banks to one 256 KB page. In that case a page base is forced in, and the inner bank number is masked with a mask whose width scales with the window size. A fold bit makes the second 2 KB region reuse the banks of the first.

In 4 KB mode, each half picks its bank register through a small selector latch. When the parameter `LATCH_EN` is 1, the mapper snoops tile fetches from two trigger rows in each half and updates that half's latch. The new selection applies from the next fetch onward. When `LATCH_EN` is 0, the selectors stay at their reset values.

Configuration is loaded through a simple byte-wide write port. The output address is combinational from the fetch address and the registered state.

Top module: `chr_bank_mapper`

## Requirements
- R1: The reset state is as follows: all bank registers are 0, the granularity is 8 KB, block confinement is on with page 0, the fold bit is off, and the selectors are lower=0 and upper=4. Reset therefore maps every fetch address to itself.
- R2: The write port is decoded as follows. A write to address n (0..7) loads bits [7:0] of bank register n. A write to address 8+n loads bits [15:8] of bank register n. Address 16 loads the mode byte and address 17 loads the outer byte. Each write is visible from the next clock cycle.
- R3: Mode byte bits [4:3] select the granularity: 00 = 8 KB, 01 = 4 KB, 10 = 2 KB, 11 = 1 KB. The in-window offset is the low 13, 12, 11 or 10 bits of the fetch address.
- R4: In 8 KB mode, bank register 0 supplies the bank, and the output is (bank << 13) | fetch[12:0].
- R5: In 2 KB mode, window w uses register 2w. In 1 KB mode, window w uses register w. The output is (bank << 11) | fetch[10:0] in 2 KB mode and (bank << 10) | fetch[9:0] in 1 KB mode.
- R6: When outer bit 5 is 0, the page is {outer[4], outer[3], outer[0]}. The bank is then ((page·256) >> s) | (reg & (0xFF >> s)), where s = 3, 2, 1 or 0 for 8, 4, 2 or 1 KB.
- R7: When outer bit 5 is 1, the full 16-bit register is the bank, and the result is truncated to CHR_AW bits.
- R8: In 2 KB and 1 KB modes, outer bit 7 makes fetches in 0x0800–0x0FFF use the registers of 0x0000–0x07FF. The range 0x1800–0x1FFF is not affected, and the bit has no effect in 8 KB or 4 KB mode.
- R9: In 4 KB mode, the lower half uses register[lower selector] and the upper half uses register[upper selector]. The output is (bank << 12) | fetch[11:0].
- R10: A strobed fetch with address bits [11:4] = 0xFD sets the selector of half fetch[12] to fetch[12]·4. A match on 0xFE sets it to fetch[12]·4+2. The triggering fetch is mapped with the old selector. Unstrobed addresses and other rows change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write byte |
| ppu_rd | input | 1 | Pattern fetch strobe, used for selector snooping |
| ppu_addr | input | 13 | Pattern-table fetch address |
| chr_addr | output | CHR_AW | Physical graphics memory address |

## Verification
On every cycle, the assertions check several properties. The mode and outer writes must land in the state. The selectors must stay inside their half, with the lower one in {0,2} and the upper one in {4,6}, and each trigger row must load the value it names. In 8 KB mode the offset must pass through unchanged. In 1 KB confined mode the page must appear in the top address bits.

Other behaviours can only be shown by the bench scenarios that compare full addresses. These are the base-and-mask scaling across all four granularities, the fold bit's reach, the truncation of unconfined banks, and the one-fetch lag of a selector update.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;

  localparam int NUM_BANKS = 8;
  localparam int REG_W     = 16;
  localparam int IDX_W     = $clog2(NUM_BANKS);
  localparam int CFG_AW    = IDX_W + 2;

  typedef enum logic [1:0] {
    GRAN_8K = 2'b00,
    GRAN_4K = 2'b01,
    GRAN_2K = 2'b10,
    GRAN_1K = 2'b11
  } gran_e;

  typedef struct packed {
    logic       fold;   // 2nd 2 KB region reuses the first
    logic       flat;   // 1 = no page confinement
    logic [2:0] page;   // 256 KB page number
  } outer_t;

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chrmap_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [CFG_AW-1:0]                  waddr_i,
  input  logic [7:0]                         wdata_i,
  output logic [NUM_BANKS-1:0][REG_W-1:0]    banks_o,
  output gran_e                              gran_o,
  output outer_t                             outer_o
);

  localparam logic [CFG_AW-1:0] HI_BASE    = CFG_AW'(NUM_BANKS);
  localparam logic [CFG_AW-1:0] MODE_ADDR  = CFG_AW'(2 * NUM_BANKS);
  localparam logic [CFG_AW-1:0] OUTER_ADDR = CFG_AW'(2 * NUM_BANKS + 1);

  logic [NUM_BANKS-1:0][REG_W-1:0] banks_q, banks_d;
  gran_e  gran_q, gran_d;
  outer_t outer_q, outer_d;
  logic [IDX_W-1:0] idx;

  assign idx = waddr_i[IDX_W-1:0];

  always_comb begin
    banks_d = banks_q;
    gran_d  = gran_q;
    outer_d = outer_q;
    if (waddr_i < HI_BASE) begin
      banks_d[idx][7:0] = wdata_i;
    end else if (waddr_i < MODE_ADDR) begin
      banks_d[idx][15:8] = wdata_i;
    end else if (waddr_i == MODE_ADDR) begin
      gran_d = gran_e'(wdata_i[4:3]);
    end else if (waddr_i == OUTER_ADDR) begin
      outer_d.fold = wdata_i[7];
      outer_d.flat = wdata_i[5];
      outer_d.page = {wdata_i[4], wdata_i[3], wdata_i[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      banks_q <= '0;
      gran_q  <= GRAN_8K;
      outer_q <= '0;
    end else if (we_i) begin
      banks_q <= banks_d;
      gran_q  <= gran_d;
      outer_q <= outer_d;
    end
  end

  assign banks_o = banks_q;
  assign gran_o  = gran_q;
  assign outer_o = outer_q;

  // R2: mode and outer bytes land in state on the next cycle
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && waddr_i == MODE_ADDR) |=> (gran_q == gran_e'($past(wdata_i[4:3]))));
  a_r2_outer_load: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && waddr_i == OUTER_ADDR) |=>
      (outer_q.flat == $past(wdata_i[5]) && outer_q.fold == $past(wdata_i[7])));

endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
  import chrmap_pkg::*;
#(
  parameter bit LATCH_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [8:0]       row_i,     // fetch address bits [12:4]
  output logic [IDX_W-1:0] sel_lo_o,
  output logic [IDX_W-1:0] sel_hi_o
);

  localparam logic [7:0] ROW_A = 8'hFD;
  localparam logic [7:0] ROW_B = 8'hFE;
  localparam logic [IDX_W-1:0] LO_RST = IDX_W'(0);
  localparam logic [IDX_W-1:0] HI_RST = IDX_W'(4);

  generate
    if (LATCH_EN) begin : g_snoop
      logic [IDX_W-1:0] lo_q, lo_d, hi_q, hi_d;
      logic hit_a, hit_b, upper;
      logic [IDX_W-1:0] newval;

      assign hit_a = rd_i && (row_i[7:0] == ROW_A);
      assign hit_b = rd_i && (row_i[7:0] == ROW_B);
      assign upper = row_i[8];

      always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        newval = IDX_W'({upper, 1'b0, 1'b0}) | (hit_b ? IDX_W'(2) : IDX_W'(0));
        if (hit_a || hit_b) begin
          if (upper) hi_d = newval;
          else       lo_d = newval;
        end
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= LO_RST;
          hi_q <= HI_RST;
        end else if (hit_a || hit_b) begin
          lo_q <= lo_d;
          hi_q <= hi_d;
        end
      end

      assign sel_lo_o = lo_q;
      assign sel_hi_o = hi_q;

      // R10: each trigger row loads the selector it names
      a_r10_fe_lower: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_i && row_i == {1'b0, ROW_B}) |=> (sel_lo_o == IDX_W'(2)));
      a_r10_fd_upper: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_i && row_i == {1'b1, ROW_A}) |=> (sel_hi_o == IDX_W'(4)));
      a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
        (!rd_i) |=> ($stable(sel_lo_o) && $stable(sel_hi_o)));
    end else begin : g_fixed
      assign sel_lo_o = LO_RST;
      assign sel_hi_o = HI_RST;
    end
  endgenerate

  // R9: selectors never leave their own half
  a_r9_halves: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_lo_o[2] == 1'b0) && (sel_hi_o[2] == 1'b1) && (sel_lo_o[0] == 1'b0) && (sel_hi_o[0] == 1'b0));

endmodule

// File: rtl/chr_addr_calc.sv
module chr_addr_calc
  import chrmap_pkg::*;
#(
  parameter int CHR_AW = 21
) (
  input  logic [NUM_BANKS-1:0][REG_W-1:0] banks_i,
  input  gran_e                           gran_i,
  input  outer_t                          outer_i,
  input  logic [IDX_W-1:0]                sel_lo_i,
  input  logic [IDX_W-1:0]                sel_hi_i,
  input  logic [12:0]                     ppu_addr_i,
  output logic [CHR_AW-1:0]               chr_addr_o
);

  logic [2:0]        win;
  logic [IDX_W-1:0]  sel;
  logic [1:0]        shamt;
  logic [3:0]        offbits;
  logic [REG_W-1:0]  base_n, mask_n, raw, bank_n;
  logic [CHR_AW-1:0] offmask;

  always_comb begin
    win = ppu_addr_i[12:10];
    if ((gran_i == GRAN_2K || gran_i == GRAN_1K) && outer_i.fold &&
        ppu_addr_i[12:11] == 2'b01) begin
      win[1] = 1'b0;
    end
    unique case (gran_i)
      GRAN_8K: begin sel = '0;                              shamt = 2'd3; end
      GRAN_4K: begin sel = ppu_addr_i[12] ? sel_hi_i : sel_lo_i; shamt = 2'd2; end
      GRAN_2K: begin sel = {win[2:1], 1'b0};                shamt = 2'd1; end
      default: begin sel = win;                             shamt = 2'd0; end
    endcase
    offbits = 4'd10 + {2'b00, shamt};
    base_n  = {{(REG_W-11){1'b0}}, outer_i.page, 8'h00} >> shamt;
    mask_n  = {{(REG_W-8){1'b0}}, 8'hFF} >> shamt;
    raw     = banks_i[sel];
    bank_n  = outer_i.flat ? raw : (base_n | (raw & mask_n));
    offmask = (CHR_AW'(1) << offbits) - CHR_AW'(1);
    chr_addr_o = (CHR_AW'(bank_n) << offbits) | (CHR_AW'(ppu_addr_i) & offmask);
  end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chrmap_pkg::*;
#(
  parameter int CHR_AW   = 21,
  parameter bit LATCH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              ppu_rd,
  input  logic [12:0]       ppu_addr,
  output logic [CHR_AW-1:0] chr_addr
);

  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [NUM_BANKS-1:0][REG_W-1:0] banks;
  gran_e            gran;
  outer_t           outer;
  logic [IDX_W-1:0] sel_lo, sel_hi;

  chr_bank_regs u_regs (
    .clk(clk), .rst_ni(rst_ni), .we_i(cfg_we), .waddr_i(cfg_addr),
    .wdata_i(cfg_wdata), .banks_o(banks), .gran_o(gran), .outer_o(outer)
  );

  chr_fetch_latch #(.LATCH_EN(LATCH_EN)) u_latch (
    .clk(clk), .rst_ni(rst_ni), .rd_i(ppu_rd), .row_i(ppu_addr[12:4]),
    .sel_lo_o(sel_lo), .sel_hi_o(sel_hi)
  );

  chr_addr_calc #(.CHR_AW(CHR_AW)) u_calc (
    .banks_i(banks), .gran_i(gran), .outer_i(outer), .sel_lo_i(sel_lo),
    .sel_hi_i(sel_hi), .ppu_addr_i(ppu_addr), .chr_addr_o(chr_addr)
  );

  // R4: 8 KB windows pass the whole fetch offset through
  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_ni)
    (gran == GRAN_8K) |-> (chr_addr[12:0] == ppu_addr));

  generate
    if (CHR_AW >= 21) begin : g_page_chk
      // R6: confined 1 KB banks place the page in bits [20:18]
      a_r6_page_bits: assert property (@(posedge clk) disable iff (!rst_ni)
        (gran == GRAN_1K && !outer.flat) |-> (chr_addr[20:18] == outer.page));
    end
  endgenerate

endmodule

// File: tb/sim_chr_bank_mapper.sv
module sim_chr_bank_mapper;

  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [7:0]    cfg_wdata;
  logic          ppu_rd;
  logic [12:0]   ppu_addr;
  logic [AW-1:0] chr_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  chr_bank_mapper #(.CHR_AW(AW), .LATCH_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
  );

  // {mode byte, outer byte, fetch address, expected address}
  localparam int NV = 15;
  localparam logic [49:0] VEC [NV] = '{
    {8'h00, 8'h00, 13'h1234, 21'h007234},  // R4 R6
    {8'h00, 8'h20, 13'h0005, 21'h046005},  // R2 R7
    {8'h00, 8'h19, 13'h1FFF, 21'h1C7FFF},  // R6
    {8'h08, 8'h00, 13'h0ABC, 21'h023ABC},  // R9
    {8'h08, 8'h00, 13'h1ABC, 21'h02BABC},  // R9
    {8'h10, 8'h00, 13'h0900, 21'h033900},  // R5
    {8'h10, 8'h80, 13'h0900, 21'h011900},  // R8
    {8'h10, 8'h80, 13'h1900, 21'h037900},  // R8
    {8'h18, 8'h00, 13'h0C10, 21'h022410},  // R5 R3
    {8'h18, 8'h80, 13'h0C10, 21'h011410},  // R8
    {8'h18, 8'h19, 13'h1400, 21'h1F3400},  // R6
    {8'h18, 8'h20, 13'h1C00, 21'h1C0400},  // R7
    {8'h00, 8'h80, 13'h0900, 21'h006900},  // R8
    {8'h10, 8'h19, 13'h0000, 21'h1D1800},  // R6
    {8'h08, 8'h19, 13'h1000, 21'h1EB000}   // R6 R9
  };

  function automatic string vec_tag(int i);
    case (i)
      0:            return "R4";
      1, 11:        return "R7";
      2, 10, 13, 14: return "R6";
      3, 4:         return "R9";
      5:            return "R5";
      8:            return "R3";
      default:      return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: chr_addr=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fetch(logic rd, logic [12:0] a, logic [AW-1:0] exp, string tag);
    @(negedge clk);
    ppu_rd = rd; ppu_addr = a;
    #2;
    check(tag, chr_addr, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ppu_rd = 1'b0; ppu_addr = '0;
    #1 do_reset();

    // R1: identity mapping after reset
    fetch(1'b0, 13'h1234, 21'h001234, "R1");
    fetch(1'b0, 13'h0ABC, 21'h000ABC, "R1");

    // R2: load bank registers (low bytes at n, high bytes at 8+n)
    cfg_write(5'd0, 8'h23); cfg_write(5'd8, 8'h01);
    cfg_write(5'd1, 8'h45); cfg_write(5'd2, 8'h67);
    cfg_write(5'd3, 8'h89); cfg_write(5'd4, 8'hAB);
    cfg_write(5'd5, 8'hCD); cfg_write(5'd6, 8'hEF);
    cfg_write(5'd7, 8'h01); cfg_write(5'd15, 8'h07);

    for (int i = 0; i < NV; i++) begin
      cfg_write(5'd16, VEC[i][49:42]);
      cfg_write(5'd17, VEC[i][41:34]);
      fetch(1'b0, VEC[i][33:21], VEC[i][20:0], vec_tag(i));
    end

    // R10: selector snooping in 4 KB mode, confined page 0
    cfg_write(5'd16, 8'h08);
    cfg_write(5'd17, 8'h00);
    fetch(1'b1, 13'h0FE8, 21'h023FE8, "R10");  // old selector on trigger fetch
    fetch(1'b0, 13'h0000, 21'h027000, "R10");  // lower now reg2
    fetch(1'b1, 13'h0FD4, 21'h027FD4, "R10");
    fetch(1'b0, 13'h0010, 21'h023010, "R10");  // lower back to reg0
    fetch(1'b0, 13'h1FE0, 21'h02BFE0, "R10");  // no strobe
    fetch(1'b0, 13'h1000, 21'h02B000, "R10");  // upper unchanged
    fetch(1'b1, 13'h1FC0, 21'h02BFC0, "R10");  // other row
    fetch(1'b0, 13'h1000, 21'h02B000, "R10");
    fetch(1'b1, 13'h1FE4, 21'h02BFE4, "R10");
    fetch(1'b0, 13'h1004, 21'h02F004, "R10");  // upper now reg6
    fetch(1'b1, 13'h1FD0, 21'h02FFD0, "R10");
    fetch(1'b0, 13'h1000, 21'h02B000, "R10");  // upper back to reg4

    // R8: fold does not touch 4 KB mode
    cfg_write(5'd17, 8'h80);
    fetch(1'b0, 13'h0900, 21'h023900, "R8");

    // R1: second reset restores registers and selectors
    do_reset();
    fetch(1'b0, 13'h1ABC, 21'h001ABC, "R1");
    cfg_write(5'd16, 8'h08);
    fetch(1'b0, 13'h1ABC, 21'h000ABC, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: chr_addr=%h expected=completion", chr_addr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule